// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block sequences one successive-approximation conversion. Every phase is timed in conversion-clock periods (TAD). A TAD is produced by dividing the system clock by a programmable whole number. A start request captures the configuration and opens the sample switch for a programmable number of TAD periods. A fixed synchronization gap of two TAD periods follows. The block then resolves the result one bit per TAD, most significant bit first. It drives a trial code to an external DAC and reads back a comparator decision.

The conversion phase lasts 12 TAD periods at 10-bit resolution and 14 TAD periods at 12-bit resolution. In both modes the last two periods hold and latch the finished code. When the conversion ends, the block pulses `done`, holds the result, and reports how many system cycles the whole conversion took, so throughput can be checked directly. A charge-pump enable bit is passed through a register to the analog front end.

Top module: `sar_timing_seq`

## Requirements
- R1: One TAD lasts (div_sel+1) system cycles. div_sel, samp_tad and res12 are captured when a start request is accepted.
- R2: sample_en is high for exactly max(samp_tad,1) TAD periods. These begin in the cycle after the accepting edge, and sample_en is low at all other times.
- R3: Two TAD periods separate the end of sampling from the start of the conversion phase. During this gap sample_en is low and dac_code is zero.
- R4: The conversion phase lasts 12 TAD in 10-bit mode (res12=0) and 14 TAD in 12-bit mode (res12=1). done rises exactly (S+2+L)·(div_sel+1) cycles after the accepting edge, where S is the effective sample count and L is the conversion length.
- R5: Bits are resolved MSB first, one per TAD. A trial bit is kept when cmp_hi=1 (input at or above the trial code) and cleared otherwise. The result is right-aligned: bits 9:0 in 10-bit mode with bits 11:10 zero, and bits 11:0 in 12-bit mode.
- R6: dac_code is zero outside the conversion phase.
- R7: A start request while busy is ignored, and so are configuration changes made while busy.
- R8: done is high for exactly one cycle. result stays unchanged until the next conversion completes, whatever cmp_hi does.
- R9: conv_cycles is updated together with done and equals the total number of busy cycles of that conversion.
- R10: pump_en equals pump_cfg delayed by one cycle.
- R11: After reset, busy, done, sample_en, dac_code, result and conv_cycles are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, accepted when idle |
| div_sel | input | DIV_W | TAD divisor; TAD = div_sel+1 cycles |
| samp_tad | input | SAMP_W | Sample length in TAD (0 is treated as 1) |
| res12 | input | 1 | 1 selects 12-bit mode, 0 selects 10-bit mode |
| pump_cfg | input | 1 | Charge-pump enable request |
| cmp_hi | input | 1 | Comparator: analog input at or above trial level |
| sample_en | output | 1 | Sample switch enable |
| dac_code | output | 12 | Trial code for the DAC |
| result | output | 12 | Right-aligned conversion result |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Conversion in progress |
| conv_cycles | output | CYC_W | System cycles taken by the last conversion |
| pump_en | output | 1 | Registered charge-pump enable |

## Verification
The assertions assume that cmp_hi settles combinationally from dac_code within the same cycle. The bench guarantees this by modelling the comparator as a direct compare of a held analog value against dac_code. They also assume the analog value does not move during a conversion. The bench changes it only after done, and then only to show that the result holds. Start pulses and configuration changes are driven away from the clock edge, and deliberate mid-conversion pokes are the only starts issued while busy.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    localparam int RES_HI   = 12;
    localparam int RES_LO   = 10;
    localparam int SYNC_TAD = 2;
    localparam int LATCH_TAD = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_SYNC,
        PH_CONV
    } phase_e;

    typedef struct packed {
        logic            m12;
        logic [RES_HI-1:0] acc;
    } conv_state_t;

    function automatic int conv_len(input logic m12);
        return (m12 ? RES_HI : RES_LO) + LATCH_TAD;
    endfunction

    function automatic logic [RES_HI-1:0] msb_mask(input logic m12);
        return m12 ? (RES_HI'(1) << (RES_HI-1)) : (RES_HI'(1) << (RES_LO-1));
    endfunction
endpackage

// File: rtl/tad_tick_gen.sv
module tad_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (cnt == div)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart && div != '0) |=> !tick);
endmodule

// File: rtl/sar_bit_core.sv
module sar_bit_core
    import sar_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              m12,
    input  logic              step,
    input  logic              cmp_hi,
    output logic [RES_HI-1:0] trial,
    output logic [RES_HI-1:0] acc
);
    logic [RES_HI-1:0] mask;

    assign trial = acc | mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            mask <= '0;
        end else if (load) begin
            acc  <= '0;
            mask <= msb_mask(m12);
        end else if (step && mask != '0) begin
            if (cmp_hi)
                acc <= acc | mask;
            mask <= mask >> 1;
        end
    end

    // R5
    mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask));
endmodule

// File: rtl/sar_timing_seq.sv
module sar_timing_seq
    import sar_seq_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int SAMP_W = 8,
    parameter int CYC_W  = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [SAMP_W-1:0] samp_tad,
    input  logic              res12,
    input  logic              pump_cfg,
    input  logic              cmp_hi,
    output logic              sample_en,
    output logic [RES_HI-1:0] dac_code,
    output logic [RES_HI-1:0] result,
    output logic              done,
    output logic              busy,
    output logic [CYC_W-1:0]  conv_cycles,
    output logic              pump_en
);
    localparam int PH_W = (SAMP_W > 4) ? SAMP_W : 4;

    phase_e            state;
    logic [DIV_W-1:0]  div_q;
    logic [PH_W-1:0]   samp_q;
    logic              m12_q;
    logic [PH_W-1:0]   ph_cnt;
    logic [CYC_W-1:0]  cyc_cnt;
    logic              tick;
    logic              restart;
    logic              load_conv;
    logic              step;
    logic [RES_HI-1:0] trial;
    conv_state_t       cs;

    assign restart   = (state == PH_IDLE) && start;
    assign load_conv = (state == PH_SYNC) && tick && (ph_cnt == PH_W'(SYNC_TAD-1));
    assign step      = (state == PH_CONV) && tick;
    assign busy      = (state != PH_IDLE);
    assign sample_en = (state == PH_SAMPLE);
    assign dac_code  = (state == PH_CONV) ? trial : '0;
    assign cs.m12    = m12_q;

    tad_tick_gen #(.DIV_W(DIV_W)) i_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .div     (div_q),
        .tick    (tick)
    );

    sar_bit_core i_core (
        .clk    (clk),
        .rst    (rst),
        .load   (load_conv),
        .m12    (m12_q),
        .step   (step),
        .cmp_hi (cmp_hi),
        .trial  (trial),
        .acc    (cs.acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= PH_IDLE;
            div_q       <= '0;
            samp_q      <= PH_W'(1);
            m12_q       <= 1'b0;
            ph_cnt      <= '0;
            cyc_cnt     <= '0;
            done        <= 1'b0;
            result      <= '0;
            conv_cycles <= '0;
            pump_en     <= 1'b0;
        end else begin
            pump_en <= pump_cfg;
            done    <= 1'b0;
            if (state == PH_IDLE) begin
                if (start) begin
                    state   <= PH_SAMPLE;
                    div_q   <= div_sel;
                    samp_q  <= (samp_tad == '0) ? PH_W'(1) : PH_W'(samp_tad);
                    m12_q   <= res12;
                    ph_cnt  <= '0;
                    cyc_cnt <= '0;
                end
            end else begin
                cyc_cnt <= cyc_cnt + 1'b1;
                if (tick) begin
                    ph_cnt <= ph_cnt + 1'b1;
                    case (state)
                        PH_SAMPLE: if (ph_cnt == samp_q - 1'b1) begin
                            state  <= PH_SYNC;
                            ph_cnt <= '0;
                        end
                        PH_SYNC: if (ph_cnt == PH_W'(SYNC_TAD-1)) begin
                            state  <= PH_CONV;
                            ph_cnt <= '0;
                        end
                        PH_CONV: if (ph_cnt == PH_W'(conv_len(cs.m12) - 1)) begin
                            state       <= PH_IDLE;
                            ph_cnt      <= '0;
                            done        <= 1'b1;
                            result      <= cs.acc;
                            conv_cycles <= cyc_cnt + 1'b1;
                        end
                        default: ph_cnt <= '0;
                    endcase
                end
            end
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));

    // R6
    sample_dac_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> (dac_code == '0));

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SAMPLE && start) |=> busy);

    // R10
    pump_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pump_en == $past(pump_cfg)));
endmodule

// File: tb/test_sar_timing_seq.sv
module test_sar_timing_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  div_sel = '0;
    logic [7:0]  samp_tad = 8'd1;
    logic        res12 = 1'b0;
    logic        pump_cfg = 1'b0;
    logic        cmp_hi;
    logic        sample_en;
    logic [11:0] dac_code;
    logic [11:0] result;
    logic        done;
    logic        busy;
    logic [17:0] conv_cycles;
    logic        pump_en;
    logic [11:0] vin = '0;

    int checks = 0;
    int failures = 0;

    assign cmp_hi = (vin >= dac_code);

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_timing_seq i_sar_timing_seq (
        .clk(clk), .rst(rst), .start(start), .div_sel(div_sel),
        .samp_tad(samp_tad), .res12(res12), .pump_cfg(pump_cfg),
        .cmp_hi(cmp_hi), .sample_en(sample_en), .dac_code(dac_code),
        .result(result), .done(done), .busy(busy),
        .conv_cycles(conv_cycles), .pump_en(pump_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input int n, input int s, input bit m12,
                            input int v, input bit poke);
        int seff = (s == 0) ? 1 : s;
        int len  = m12 ? 14 : 12;
        int tad  = n + 1;
        int tot  = (seff + 2 + len) * tad;
        int conv_at = (seff + 2) * tad;
        int c = 0;
        int samp_bad = 0;
        int dac_bad = 0;
        logic [11:0] held;
        @(negedge clk);
        div_sel = 8'(n); samp_tad = 8'(s); res12 = m12; vin = 12'(v);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done && c < 3000) begin
            if (sample_en != (c < seff * tad)) samp_bad++;
            if (c < conv_at && dac_code != 0) dac_bad++;
            if (poke && c == 5) begin start = 1'b1; div_sel = 8'(n + 3); samp_tad = 8'd7; res12 = ~m12; end
            if (poke && c == 6) begin start = 1'b0; div_sel = 8'(n); samp_tad = 8'(s); res12 = m12; end
            @(posedge clk);
            @(negedge clk);
            c++;
        end
        // R4 latency, R1 TAD length, R7 when poked
        chk(c == tot, poke ? "R7 latency under busy start" : "R4 start-to-done latency", c, tot);
        // R2 sample window, R3 sync gap has no sampling
        chk(samp_bad == 0, "R2 sample_en window", samp_bad, 0);
        // R6 / R3 DAC zero before conversion phase
        chk(dac_bad == 0, "R6 dac_code zero before conversion", dac_bad, 0);
        // R5 result equals held input
        chk(result == 12'(v), "R5 result code", int'(result), v);
        // R9 cycle report
        chk(int'(conv_cycles) == tot, "R9 conv_cycles", int'(conv_cycles), tot);
        held = result;
        @(negedge clk);
        // R8 one-cycle pulse
        chk(!done, "R8 done width", int'(done), 0);
        // R6 idle DAC
        chk(dac_code == 0, "R6 dac_code idle", int'(dac_code), 0);
        vin = ~vin;
        repeat (3) @(negedge clk);
        // R8 result held
        chk(result == held, "R8 result hold", int'(result), int'(held));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int samps[4] = '{0, 1, 2, 10};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(!busy && !done && !sample_en, "R11 reset flags", int'({busy, done, sample_en}), 0);
        chk(dac_code == 0 && result == 0, "R11 reset codes", int'(result), 0);
        chk(conv_cycles == 0, "R11 reset conv_cycles", int'(conv_cycles), 0);

        // R10 pump passthrough
        pump_cfg = 1'b1;
        @(negedge clk);
        chk(pump_en == 1'b1, "R10 pump_en set", int'(pump_en), 1);
        pump_cfg = 1'b0;
        @(negedge clk);
        chk(pump_en == 1'b0, "R10 pump_en clear", int'(pump_en), 0);

        // Sweep divisor, sample length, resolution, input patterns (R1 R2 R3 R4 R5)
        for (int n = 0; n < 4; n++) begin
            for (int si = 0; si < 4; si++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int k = 0; k < 5; k++) begin
                        int mx = m ? 4095 : 1023;
                        int half = m ? 2048 : 512;
                        int v;
                        case (k)
                            0: v = 0;
                            1: v = mx;
                            2: v = half;
                            3: v = half - 1;
                            default: v = ((n * 7 + si * 3 + 1) * 677) & mx;
                        endcase
                        run_conv(n, samps[si], m[0], v, 1'b0);
                    end
                end
            end
        end

        // R7 start and config changes while busy ignored
        run_conv(2, 3, 1'b1, 1234, 1'b1);
        run_conv(0, 1, 1'b0, 777, 1'b1);

        // Exhaustive 10-bit codes at fastest timing (R5)
        for (int v = 0; v < 1024; v++) run_conv(0, 1, 1'b0, v, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule